// File: doc/BRIEF.md
# Packet Page Allocator with Queues

This block hands out and takes back the pages of a small packet buffer pool inside an Ethernet controller. Software drives it through a 3-bit command field. The commands can request a page for a frame about to be sent. They can free a chosen page, put a page on the transmit queue, drop entries from the receive queue, or wipe the whole allocator. The receive engine asks for pages on its own request line. The transmit engine reports each frame it has sent, and the page at the head of the pending queue then moves to the completed queue, or is freed straight away when auto-release is on.

The block keeps one bit per page to mark it taken and three short queues: transmit pending, transmit completed and received. It shows the allocation result, the three queue heads, how many pages are in use, four status bits and a level interrupt. A transmit allocation that fails is not lost. It stays pending and is granted as soon as any page is freed. All state is registered, and every output shows the effect of a cycle's inputs after the next rising clock edge.

Top module: `pagePoolAllocator`

## Requirements
- R1: A transmit-allocate command (code 1) takes the lowest-numbered free page, puts its number in the allocation result and sets status bit 3 (allocate done).
- R2: A transmit-allocate command with every page taken sets the allocation result to 0x80 and clears status bit 3.
- R3: While the allocation result is 0x80, freeing any page grants that page to the pending transmit allocation in the same cycle and sets status bit 3. A page can be freed by code 5, by code 4, or by a sent frame with auto-release on. Frees are applied before any allocation in a cycle.
- R4: The command code is the 3-bit field of the command byte (byte bits 7:5) and acts only when cmdValid is high. The codes are 0 no operation, 1 transmit allocate, 2 allocator reset, 3 receive pop, 4 receive pop and free, 5 free pageSel, 6 enqueue pageSel for transmit, and 7 clear both transmit queues. Code 0 changes nothing.
- R5: Code 2 frees every page, empties all three queues, sets the allocation result to 0 and clears status bit 0. All other inputs in that cycle are ignored.
- R6: usedPages equals the number of pages currently taken.
- R7: Code 6 appends pageSel to the pending queue and is dropped when that queue holds four entries. A txSent pulse pops the pending head and pushes it onto the completed queue, which drops it when full, or frees the page when autoRelease is high.
- R8: Code 7 empties the pending and completed queues and ignores a txSent pulse in the same cycle.
- R9: rxReq takes the lowest page still free after any transmit grant in that cycle, appends it to the receive queue and sets status bit 0. rxReq is ignored when no page is free.
- R10: Codes 3 and 4 pop the receive queue (code 4 also frees the popped page). Status bit 0 stays set if entries remain and is cleared when the queue becomes empty. A pop of an empty queue changes nothing else.
- R11: Each empty queue shows 0x80 at its head output. A non-empty queue shows its oldest page number.
- R12: Status bits are 3 allocate done, 2 transmit empty, 1 transmit done and 0 receive. ackEmpty clears bit 2. ackDone clears bit 1 and pops the completed queue. Bit 2 is forced high whenever the pending queue is empty, and bit 1 whenever the completed queue is non-empty.
- R13: irq is high exactly when some status bit and its intMask bit are both set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command strobe |
| cmdCode | input | 3 | Command field (bits 7:5 of the command byte) |
| pageSel | input | PAGE_W | Selected page for free and enqueue |
| ackEmpty | input | 1 | Clear transmit-empty status |
| ackDone | input | 1 | Clear transmit-done status and pop completed queue |
| intMask | input | 4 | Interrupt enable per status bit |
| autoRelease | input | 1 | Free sent pages instead of queueing them |
| txSent | input | 1 | Transmitter finished the pending head frame |
| rxReq | input | 1 | Receiver requests a page |
| allocResult | output | 8 | Last transmit allocation result, 0x80 on failure |
| txPendHead | output | 8 | Pending queue head, 0x80 when empty |
| txDoneHead | output | 8 | Completed queue head, 0x80 when empty |
| rxHead | output | 8 | Receive queue head, 0x80 when empty |
| usedPages | output | CNT_W | Count of taken pages |
| status | output | 4 | Status bits |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its default of four pages and four-entry queues. With so few pages, a handful of commands fills the pool, saturates the pending and completed queues, and leaves a transmit allocation waiting for a free page. Random traffic therefore spends much of its time at the full and empty edges, where the retry grant, the dropped enqueue and the receive-status rule on the last pop are decided.

// File: rtl/pageAllocPkg.sv
package pageAllocPkg;

  typedef enum logic [2:0] {
    CMD_NOP       = 3'd0,
    CMD_TXALLOC   = 3'd1,
    CMD_WIPE      = 3'd2,
    CMD_RXPOP     = 3'd3,
    CMD_RXPOPFREE = 3'd4,
    CMD_FREE      = 3'd5,
    CMD_ENQ       = 3'd6,
    CMD_TXCLR     = 3'd7
  } cmdCodeE;

  localparam int ST_RCV     = 0;
  localparam int ST_TXDONE  = 1;
  localparam int ST_TXEMPTY = 2;
  localparam int ST_ALLOC   = 3;

  localparam logic [7:0] NO_PAGE = 8'h80;
  localparam logic [3:0] STATUS_RESET = 4'b0100;

  // one-cycle strobes from control to datapath
  typedef struct packed {
    logic allocTx;
    logic wipe;
    logic rxPop;
    logic rxFree;
    logic freeSel;
    logic enqTx;
    logic clrTx;
    logic ackEmpty;
    logic ackDone;
    logic txSent;
    logic rxReq;
  } strobeT;

endpackage

// File: rtl/pageQueue.sv
module pageQueue #(
  parameter int DEPTH = 4,
  parameter int W = 2,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  pushData,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic [CW-1:0] countNext
);

  logic [W-1:0] slot [DEPTH];
  logic [W-1:0] slotNext [DEPTH];
  logic popOk;
  logic pushOk;
  logic [CW-1:0] afterPop;

  // pop acts on the old contents first, then the push lands behind
  always_comb begin
    popOk = pop && (count != '0);
    afterPop = count - CW'(popOk);
    for (int i = 0; i < DEPTH; i++) slotNext[i] = slot[i];
    if (popOk) begin
      for (int i = 0; i < DEPTH - 1; i++) slotNext[i] = slot[i + 1];
    end
    pushOk = push && (afterPop < CW'(DEPTH));
    for (int i = 0; i < DEPTH; i++) begin
      if (pushOk && (afterPop == CW'(i))) slotNext[i] = pushData;
    end
    countNext = clr ? '0 : (afterPop + CW'(pushOk));
  end

  always_ff @(posedge clk) begin
    if (!rstN) count <= '0;
    else       count <= countNext;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) slot[i] <= slotNext[i];
  end

  assign head = slot[0];

endmodule

// File: rtl/pageAllocCtrl.sv
module pageAllocCtrl
  import pageAllocPkg::*;
(
  input  logic       cmdValid,
  input  logic [2:0] cmdCode,
  input  logic       ackEmpty,
  input  logic       ackDone,
  input  logic       txSent,
  input  logic       rxReq,
  output strobeT     strobes
);

  cmdCodeE code;

  always_comb begin
    code = cmdCodeE'(cmdCode);
    strobes = '0;
    if (cmdValid) begin
      unique case (code)
        CMD_NOP:       ;
        CMD_TXALLOC:   strobes.allocTx = 1'b1;
        CMD_WIPE:      strobes.wipe    = 1'b1;
        CMD_RXPOP:     strobes.rxPop   = 1'b1;
        CMD_RXPOPFREE: strobes.rxFree  = 1'b1;
        CMD_FREE:      strobes.freeSel = 1'b1;
        CMD_ENQ:       strobes.enqTx   = 1'b1;
        CMD_TXCLR:     strobes.clrTx   = 1'b1;
      endcase
    end
    strobes.ackEmpty = ackEmpty;
    strobes.ackDone  = ackDone;
    strobes.txSent   = txSent && !strobes.clrTx;
    strobes.rxReq    = rxReq;
    // a wipe swallows everything else in its cycle
    if (strobes.wipe) begin
      strobes = '0;
      strobes.wipe = 1'b1;
    end
  end

endmodule

// File: rtl/pageAllocDatapath.sv
module pageAllocDatapath
  import pageAllocPkg::*;
#(
  parameter int PAGES = 4,
  localparam int PAGE_W = (PAGES > 1) ? $clog2(PAGES) : 1,
  localparam int CNT_W = $clog2(PAGES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobes,
  input  logic [PAGE_W-1:0] pageSel,
  input  logic              autoRelease,
  input  logic [3:0]        intMask,
  output logic [7:0]        allocResult,
  output logic [7:0]        txPendHead,
  output logic [7:0]        txDoneHead,
  output logic [7:0]        rxHead,
  output logic [CNT_W-1:0]  usedPages,
  output logic [3:0]        status,
  output logic              irq
);

  function automatic logic [PAGE_W-1:0] lowestFree(input logic [PAGES-1:0] m);
    logic [PAGE_W-1:0] r;
    r = '0;
    for (int i = PAGES - 1; i >= 0; i--) begin
      if (!m[i]) r = PAGE_W'(i);
    end
    return r;
  endfunction

  function automatic logic [PAGES-1:0] pageBit(input logic [PAGE_W-1:0] p);
    logic [PAGES-1:0] r;
    r = '0;
    for (int i = 0; i < PAGES; i++) begin
      if (p == PAGE_W'(i)) r[i] = 1'b1;
    end
    return r;
  endfunction

  logic [PAGES-1:0] usedMap, usedMapNext, freeMask, mapA, mapB;
  logic [7:0] allocRes, allocResNext;
  logic [3:0] stat, statNext;
  logic txTry, txGrant, rxGrant;
  logic [PAGE_W-1:0] txPick, rxPick;

  logic [PAGE_W-1:0] pendHd, doneHd, rxHd;
  logic [CNT_W-1:0] pendCnt, pendCntNext, doneCnt, doneCntNext, rxCnt, rxCntNext;
  logic pendSendOk, donePush, rxPopAny;

  assign pendSendOk = strobes.txSent && (pendCnt != '0);
  assign donePush   = pendSendOk && !autoRelease;
  assign rxPopAny   = strobes.rxPop || strobes.rxFree;

  // frees first, then the transmit grant, then the receive grant
  always_comb begin
    freeMask = '0;
    if (strobes.rxFree && (rxCnt != '0)) freeMask = freeMask | pageBit(rxHd);
    if (strobes.freeSel)                 freeMask = freeMask | pageBit(pageSel);
    if (pendSendOk && autoRelease)       freeMask = freeMask | pageBit(pendHd);
    mapA = usedMap & ~freeMask;

    txTry   = strobes.allocTx || ((allocRes == NO_PAGE) && (freeMask != '0));
    txGrant = txTry && !(&mapA);
    txPick  = lowestFree(mapA);
    mapB    = txGrant ? (mapA | pageBit(txPick)) : mapA;

    rxGrant = strobes.rxReq && !(&mapB);
    rxPick  = lowestFree(mapB);
    usedMapNext = rxGrant ? (mapB | pageBit(rxPick)) : mapB;

    allocResNext = allocRes;
    if (strobes.allocTx) allocResNext = NO_PAGE;
    if (txGrant)         allocResNext = 8'(txPick);

    if (strobes.wipe) begin
      usedMapNext  = '0;
      allocResNext = '0;
    end
  end

  always_comb begin
    statNext = stat;
    if (strobes.allocTx)  statNext[ST_ALLOC] = 1'b0;
    if (txGrant)          statNext[ST_ALLOC] = 1'b1;
    if (strobes.ackEmpty) statNext[ST_TXEMPTY] = 1'b0;
    if (strobes.ackDone)  statNext[ST_TXDONE] = 1'b0;
    if (strobes.wipe)     statNext[ST_RCV] = 1'b0;
    else if (rxPopAny)    statNext[ST_RCV] = (rxCntNext != '0);
    else if (rxGrant)     statNext[ST_RCV] = 1'b1;
    if (pendCntNext == '0) statNext[ST_TXEMPTY] = 1'b1;
    if (doneCntNext != '0) statNext[ST_TXDONE] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      usedMap  <= '0;
      allocRes <= '0;
      stat     <= STATUS_RESET;
    end else begin
      usedMap  <= usedMapNext;
      allocRes <= allocResNext;
      stat     <= statNext;
    end
  end

  pageQueue #(.DEPTH(PAGES), .W(PAGE_W)) pendQ_i (
    .clk(clk), .rstN(rstN),
    .clr(strobes.wipe || strobes.clrTx),
    .push(strobes.enqTx), .pushData(pageSel),
    .pop(strobes.txSent),
    .head(pendHd), .count(pendCnt), .countNext(pendCntNext)
  );

  pageQueue #(.DEPTH(PAGES), .W(PAGE_W)) doneQ_i (
    .clk(clk), .rstN(rstN),
    .clr(strobes.wipe || strobes.clrTx),
    .push(donePush), .pushData(pendHd),
    .pop(strobes.ackDone),
    .head(doneHd), .count(doneCnt), .countNext(doneCntNext)
  );

  pageQueue #(.DEPTH(PAGES), .W(PAGE_W)) rxQ_i (
    .clk(clk), .rstN(rstN),
    .clr(strobes.wipe),
    .push(rxGrant), .pushData(rxPick),
    .pop(rxPopAny),
    .head(rxHd), .count(rxCnt), .countNext(rxCntNext)
  );

  always_comb begin
    usedPages = '0;
    for (int i = 0; i < PAGES; i++) usedPages = usedPages + CNT_W'(usedMap[i]);
  end

  assign allocResult = allocRes;
  assign txPendHead  = (pendCnt == '0) ? NO_PAGE : 8'(pendHd);
  assign txDoneHead  = (doneCnt == '0) ? NO_PAGE : 8'(doneHd);
  assign rxHead      = (rxCnt == '0)   ? NO_PAGE : 8'(rxHd);
  assign status      = stat;
  assign irq         = |(stat & intMask);

endmodule

// File: rtl/pagePoolAllocator.sv
module pagePoolAllocator
  import pageAllocPkg::*;
#(
  parameter int PAGES = 4,
  localparam int PAGE_W = (PAGES > 1) ? $clog2(PAGES) : 1,
  localparam int CNT_W = $clog2(PAGES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [2:0]        cmdCode,
  input  logic [PAGE_W-1:0] pageSel,
  input  logic              ackEmpty,
  input  logic              ackDone,
  input  logic [3:0]        intMask,
  input  logic              autoRelease,
  input  logic              txSent,
  input  logic              rxReq,
  output logic [7:0]        allocResult,
  output logic [7:0]        txPendHead,
  output logic [7:0]        txDoneHead,
  output logic [7:0]        rxHead,
  output logic [CNT_W-1:0]  usedPages,
  output logic [3:0]        status,
  output logic              irq
);

  strobeT strobes;

  pageAllocCtrl ctrl_i (
    .cmdValid(cmdValid), .cmdCode(cmdCode),
    .ackEmpty(ackEmpty), .ackDone(ackDone),
    .txSent(txSent), .rxReq(rxReq),
    .strobes(strobes)
  );

  pageAllocDatapath #(.PAGES(PAGES)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .pageSel(pageSel), .autoRelease(autoRelease), .intMask(intMask),
    .allocResult(allocResult), .txPendHead(txPendHead),
    .txDoneHead(txDoneHead), .rxHead(rxHead),
    .usedPages(usedPages), .status(status), .irq(irq)
  );

endmodule

// File: rtl/pageAllocChk.sv
module pageAllocChk #(
  parameter int PAGES = 4,
  localparam int CNT_W = $clog2(PAGES + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             cmdValid,
  input logic [2:0]       cmdCode,
  input logic             autoRelease,
  input logic             txSent,
  input logic [7:0]       allocResult,
  input logic [7:0]       txPendHead,
  input logic [7:0]       txDoneHead,
  input logic [7:0]       rxHead,
  input logic [CNT_W-1:0] usedPages,
  input logic [3:0]       status
);

  // R1
  grant_when_room_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdCode == 3'd1 && usedPages < CNT_W'(PAGES))
    |=> (allocResult != 8'h80 && status[3]));

  // R2
  fail_when_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdCode == 3'd1 && usedPages == CNT_W'(PAGES) && !(txSent && autoRelease))
    |=> (allocResult == 8'h80 && !status[3]));

  // R5
  wipe_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdCode == 3'd2)
    |=> (usedPages == '0 && allocResult == 8'h00 && rxHead == 8'h80
         && txPendHead == 8'h80 && txDoneHead == 8'h80));

  // R6
  used_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    usedPages <= CNT_W'(PAGES));

  // R10
  rcv_tracks_queue_chk: assert property (@(posedge clk) disable iff (!rstN)
    status[0] == (rxHead != 8'h80));

  // R12
  tx_empty_forced_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txPendHead == 8'h80) |-> status[2]);

  // R12
  tx_done_forced_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txDoneHead != 8'h80) |-> status[1]);

endmodule

bind pagePoolAllocator pageAllocChk #(.PAGES(PAGES)) chk_i (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
  .autoRelease(autoRelease), .txSent(txSent),
  .allocResult(allocResult), .txPendHead(txPendHead),
  .txDoneHead(txDoneHead), .rxHead(rxHead),
  .usedPages(usedPages), .status(status)
);

// File: tb/pagePoolAllocator_tb_top.sv
module pagePoolAllocator_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [2:0] cmdCode = 3'd0;
  logic [1:0] pageSel = 2'd0;
  logic ackEmpty = 1'b0, ackDone = 1'b0;
  logic [3:0] intMask = 4'd0;
  logic autoRelease = 1'b0, txSent = 1'b0, rxReq = 1'b0;
  logic [7:0] allocResult, txPendHead, txDoneHead, rxHead;
  logic [2:0] usedPages;
  logic [3:0] status;
  logic irq;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  pagePoolAllocator #(.PAGES(4)) dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .pageSel(pageSel), .ackEmpty(ackEmpty), .ackDone(ackDone),
    .intMask(intMask), .autoRelease(autoRelease), .txSent(txSent),
    .rxReq(rxReq), .allocResult(allocResult), .txPendHead(txPendHead),
    .txDoneHead(txDoneHead), .rxHead(rxHead), .usedPages(usedPages),
    .status(status), .irq(irq)
  );

  // reference model
  logic [3:0] mMap;
  logic [7:0] mRes;
  logic [3:0] mStat;
  int pq[4], dq[4], rq[4];
  int pc, dc, rc;

  function automatic int lowFree(input logic [3:0] m);
    for (int i = 0; i < 4; i++) if (!m[i]) return i;
    return -1;
  endfunction

  function automatic int popCnt(input logic [3:0] m);
    int n = 0;
    for (int i = 0; i < 4; i++) n += int'(m[i]);
    return n;
  endfunction

  task automatic modelReset();
    mMap = '0; mRes = 8'h00; mStat = 4'b0100; pc = 0; dc = 0; rc = 0;
  endtask

  task automatic modelStep();
    logic [3:0] fm, map;
    bit wipe, clr, tsEff, tryTx, rxg, sentOk, rxPopCmd;
    int hp, pick, code;
    code = cmdValid ? int'(cmdCode) : 0;
    wipe = cmdValid && code == 2;
    if (wipe) begin
      mMap = '0; mRes = 8'h00; pc = 0; dc = 0; rc = 0; mStat[0] = 1'b0;
      mStat[2] = 1'b1;
      return;
    end
    clr = cmdValid && code == 7;
    tsEff = txSent && !clr;
    sentOk = tsEff && pc > 0;
    fm = '0;
    if (cmdValid && code == 4 && rc > 0) fm[rq[0]] = 1'b1;
    if (cmdValid && code == 5) fm[pageSel] = 1'b1;
    if (sentOk && autoRelease) fm[pq[0]] = 1'b1;
    map = mMap & ~fm;
    tryTx = (cmdValid && code == 1) || (mRes == 8'h80 && fm != 0);
    if (cmdValid && code == 1) begin mRes = 8'h80; mStat[3] = 1'b0; end
    if (tryTx && map != 4'hF) begin
      pick = lowFree(map); map[pick] = 1'b1; mRes = 8'(pick); mStat[3] = 1'b1;
    end
    rxg = rxReq && map != 4'hF;
    if (rxg) begin pick = lowFree(map); map[pick] = 1'b1; end
    mMap = map;
    // pending queue
    hp = pq[0];
    if (sentOk) begin for (int i = 0; i < 3; i++) pq[i] = pq[i+1]; pc--; end
    if (cmdValid && code == 6 && pc < 4) begin pq[pc] = int'(pageSel); pc++; end
    // completed queue
    if (ackDone && dc > 0) begin for (int i = 0; i < 3; i++) dq[i] = dq[i+1]; dc--; end
    if (sentOk && !autoRelease && dc < 4) begin dq[dc] = hp; dc++; end
    if (clr) begin pc = 0; dc = 0; end
    // receive queue
    rxPopCmd = cmdValid && (code == 3 || code == 4);
    if (rxPopCmd && rc > 0) begin for (int i = 0; i < 3; i++) rq[i] = rq[i+1]; rc--; end
    if (rxg) begin rq[rc] = pick; rc++; end
    if (ackEmpty) mStat[2] = 1'b0;
    if (ackDone) mStat[1] = 1'b0;
    if (rxPopCmd) mStat[0] = (rc != 0);
    else if (rxg) mStat[0] = 1'b1;
    if (pc == 0) mStat[2] = 1'b1;
    if (dc != 0) mStat[1] = 1'b1;
  endtask

  task automatic check(input string tag, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic int headOf(input int c, input int v);
    return (c == 0) ? 32'h80 : v;
  endfunction

  task automatic compareAll();
    check("R1", "allocResult", int'(allocResult), int'(mRes));
    check("R7", "txPendHead", int'(txPendHead), headOf(pc, pq[0]));
    check("R11", "txDoneHead", int'(txDoneHead), headOf(dc, dq[0]));
    check("R9", "rxHead", int'(rxHead), headOf(rc, rq[0]));
    check("R6", "usedPages", int'(usedPages), popCnt(mMap));
    check("R12", "status", int'(status), int'(mStat));
    check("R13", "irq", int'(irq), int'(|(mStat & intMask)));
  endtask

  // one clock: inputs already driven at negedge
  task automatic step();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compareAll();
    cmdValid = 1'b0; ackEmpty = 1'b0; ackDone = 1'b0; txSent = 1'b0; rxReq = 1'b0;
  endtask

  task automatic cmd(input int c, input int p);
    cmdValid = 1'b1; cmdCode = 3'(c); pageSel = 2'(p);
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R11", "reset rxHead", int'(rxHead), 32'h80);
    check("R12", "reset status", int'(status), 32'h4);
    compareAll();

    // R1: lowest free page, four in a row
    for (int i = 0; i < 4; i++) begin
      cmd(1, 0);
      check("R1", "alloc page", int'(allocResult), i);
    end
    check("R6", "pool full count", int'(usedPages), 4);
    // R2: fifth allocation fails
    cmd(1, 0);
    check("R2", "fail code", int'(allocResult), 32'h80);
    check("R2", "alloc bit cleared", int'(status[3]), 0);
    // R9: receive request ignored while full
    rxReq = 1'b1; step();
    check("R9", "rx ignored when full", int'(rxHead), 32'h80);
    // R3: freeing page 2 grants the pending allocation
    cmd(5, 2);
    check("R3", "retry grant", int'(allocResult), 2);
    check("R3", "alloc bit set", int'(status[3]), 1);
    // R4: code 0 changes nothing
    cmd(0, 1);
    check("R4", "nop keeps count", int'(usedPages), 4);
    // R7: enqueue five, the fifth is dropped
    for (int i = 0; i < 4; i++) cmd(6, i);
    cmd(6, 0);
    check("R7", "pending head", int'(txPendHead), 0);
    for (int i = 0; i < 4; i++) begin txSent = 1'b1; step(); end
    check("R7", "fifth enqueue dropped", int'(txPendHead), 32'h80);
    check("R7", "completed head", int'(txDoneHead), 0);
    // R12: ack transmit-done pops completed queue
    ackDone = 1'b1; step();
    check("R12", "ack pops completed", int'(txDoneHead), 1);
    check("R12", "done bit forced", int'(status[1]), 1);
    // R8: clear both transmit queues
    cmd(6, 3);
    cmd(7, 0);
    check("R8", "pending cleared", int'(txPendHead), 32'h80);
    check("R8", "completed cleared", int'(txDoneHead), 32'h80);
    // R5: wipe
    cmd(2, 0);
    check("R5", "wipe count", int'(usedPages), 0);
    check("R5", "wipe result", int'(allocResult), 0);
    // R9, R10: receive path
    rxReq = 1'b1; step();
    rxReq = 1'b1; step();
    check("R9", "rx head", int'(rxHead), 0);
    check("R9", "rcv bit", int'(status[0]), 1);
    cmd(3, 0);
    check("R10", "pop leaves entry", int'(rxHead), 1);
    check("R10", "rcv bit stays", int'(status[0]), 1);
    cmd(4, 0);
    check("R10", "pop-free empties", int'(rxHead), 32'h80);
    check("R10", "rcv bit clears", int'(status[0]), 0);
    check("R10", "popped page freed", int'(usedPages), 1);
    // R7: auto-release frees a sent page
    autoRelease = 1'b1;
    cmd(6, 0);
    txSent = 1'b1; step();
    check("R7", "auto release frees", int'(usedPages), 0);
    check("R7", "auto release skips completed", int'(txDoneHead), 32'h80);
    autoRelease = 1'b0;
    // R13: interrupt masking
    intMask = 4'b0100; @(negedge clk);
    check("R13", "irq on tx empty", int'(irq), 1);
    intMask = 4'b0001; @(negedge clk);
    check("R13", "irq masked", int'(irq), 0);

    // constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      int r;
      int c;
      if (n % 500 == 0) autoRelease = $urandom_range(0, 1) == 1;
      if (n % 100 == 0) intMask = 4'($urandom_range(0, 15));
      r = $urandom_range(0, 63);
      c = $urandom_range(0, 7);
      if (c == 2 && r != 0) c = 1;
      cmdValid = ($urandom_range(0, 3) != 0);
      cmdCode = 3'(c);
      pageSel = 2'($urandom_range(0, 3));
      ackEmpty = ($urandom_range(0, 7) == 0);
      ackDone = ($urandom_range(0, 5) == 0);
      txSent = ($urandom_range(0, 3) == 0);
      rxReq = ($urandom_range(0, 4) == 0);
      step();
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule